// File: doc/BRIEF.md
# Connected-Component Relabel and Feature Accumulator

This block runs the second pass of connected-component labeling. It takes in a stream of 2x2 pixel blocks. Each block carries its provisional label from the first pass, its block row and block column, and the number of set pixels it holds (0 to 4). For every block that has a label, the block reads the merge-resolution table through a synchronous read port and gets back the final label. It then emits that final label on an output stream.

In the same single linear pass, it keeps a record for each final label in a small feature memory. The record holds the pixel area and the smallest and largest block row and column. After the pass, software-side logic reads each record back as area, top-left corner and box height and width. All coordinates are in block units.

A controller sequences the work through four states. IDLE waits for `start`. CLEAR resets one feature entry per cycle. RUN accepts blocks. DRAIN lets the pipeline empty. The transitions are:
- IDLE->CLEAR on `start`.
- CLEAR->RUN after the last entry is cleared.
- RUN->DRAIN when a block flagged `in_last` is accepted.
- DRAIN->IDLE once both pipeline stages are empty, which is the cycle `done` pulses.

The pipeline has three steps. The acceptance cycle issues the table read. The second stage reads the feature record. The third stage writes the updated record back. When two blocks in a row resolve to the same final label, the third stage forwards its new record to the second stage.

Top module: `relabel_feature_acc`

## Requirements
- R1: After reset, `busy`, `ready`, `out_valid` and `done` are all 0.
- R2: A `start` pulse in IDLE clears the 16 feature entries one per cycle. Each entry is set to area 0, minimum row/column all ones (63) and maximum row/column 0. `ready` rises exactly 16 cycles after the edge that samples `start`. A `start` while busy has no effect.
- R3: A block accepted with a nonzero label drives `tbl_rd`=1 and `tbl_addr`=label in its acceptance cycle. The table data is expected one cycle later. `out_valid` rises after the second clock edge following acceptance, with `out_label` equal to the table content.
- R4: A block with label 0 issues no table read. It appears in the output stream as `out_label`=0 and adds nothing to any feature entry.
- R5: The area of a final label is the sum of the set-pixel counts of all its blocks.
- R6: The readout gives `fm_top`/`fm_left` as the minimum block row/column. `fm_height`/`fm_width` are max-min+1, or 0 when the area is 0.
- R7: Back-to-back blocks that resolve to the same final label all accumulate, including when their first-pass labels differ.
- R8: Blocks are accepted only while `ready` is high, which is only in RUN. Input offered otherwise is ignored. Accepting an `in_last` block drops `ready` in the next cycle. `done` pulses once the last output has left, two cycles after acceptance, and `busy` falls on the following edge.
- R9: A feature readout of `fm_addr` appears on the `fm_*` outputs one clock edge after the address is presented.
- R10: Distinct first-pass labels that the table maps to one final label share one feature record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a pass (clear, then accept blocks) |
| in_valid | input | 1 | Block offered |
| in_label | input | 6 | First-pass label, 0 = background |
| in_row | input | 6 | Block row |
| in_col | input | 6 | Block column |
| in_count | input | 3 | Set pixels in block, 0..4 |
| in_last | input | 1 | Final block of the frame |
| ready | output | 1 | Block accepted this cycle if valid |
| tbl_rd | output | 1 | Table read strobe |
| tbl_addr | output | 6 | Table read address (first-pass label) |
| tbl_data | input | 4 | Final label, valid the cycle after `tbl_rd` |
| out_valid | output | 1 | Final label stream valid |
| out_label | output | 4 | Final label (0 for background) |
| busy | output | 1 | Controller not in IDLE |
| done | output | 1 | One-cycle pulse at end of pass |
| fm_addr | input | 4 | Feature readout address |
| fm_area | output | 15 | Area of the addressed final label |
| fm_top | output | 6 | Top block row |
| fm_left | output | 6 | Left block column |
| fm_height | output | 7 | Box height in blocks |
| fm_width | output | 7 | Box width in blocks |

## Verification
Two things can fall in one cycle. The last stage writes the record of a final label while the middle stage reads the record of that same label. The bench provokes this with a block of one first-pass label followed directly by a second block of the same label. It also sends two back-to-back blocks whose different first-pass labels the table maps to one final label. Both sequences are judged only at the readout: the area must equal the sum of all counts and the box must span every block, so a stale read shows up as a missing count or a shrunken box.

// File: rtl/relabel_pkg.sv
package relabel_pkg;
    parameter int FP_W    = 6;
    parameter int FL_W    = 4;
    parameter int COORD_W = 6;
    parameter int CNT_W   = 3;
    localparam int NF     = 1 << FL_W;
    localparam int AREA_W = $clog2(4 * (1 << (2 * COORD_W)) + 1);
    localparam int SIZE_W = COORD_W + 1;

    typedef struct packed {
        logic [AREA_W-1:0]  area;
        logic [COORD_W-1:0] min_r;
        logic [COORD_W-1:0] min_c;
        logic [COORD_W-1:0] max_r;
        logic [COORD_W-1:0] max_c;
    } feat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_RUN,
        ST_DRAIN
    } state_t;

    localparam feat_t FEAT_EMPTY = '{area: '0, min_r: '1, min_c: '1, max_r: '0, max_c: '0};

    function automatic feat_t feat_merge(feat_t o, logic [COORD_W-1:0] r,
                                         logic [COORD_W-1:0] c, logic [CNT_W-1:0] n);
        feat_t f;
        f.area  = o.area + AREA_W'(n);
        f.min_r = (r < o.min_r) ? r : o.min_r;
        f.min_c = (c < o.min_c) ? c : o.min_c;
        f.max_r = (r > o.max_r) ? r : o.max_r;
        f.max_c = (c > o.max_c) ? c : o.max_c;
        return f;
    endfunction
endpackage

// File: rtl/relabel_ctrl.sv
module relabel_ctrl
    import relabel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            in_valid,
    input  logic            in_last,
    input  logic            pipe_busy,
    output state_t          state,
    output logic            ready,
    output logic            clr_en,
    output logic [FL_W-1:0] clr_addr,
    output logic            busy,
    output logic            done
);
    state_t          nxt;
    logic [FL_W-1:0] clr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            clr_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_CLEAR) clr_cnt <= clr_cnt + 1'b1;
            else                   clr_cnt <= '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_CLEAR;
            ST_CLEAR: if (clr_cnt == FL_W'(NF - 1)) nxt = ST_RUN;
            ST_RUN:   if (in_valid && in_last) nxt = ST_DRAIN;
            ST_DRAIN: if (!pipe_busy) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        ready    = 1'b0;
        clr_en   = 1'b0;
        done     = 1'b0;
        busy     = 1'b1;
        clr_addr = clr_cnt;
        unique case (state)
            ST_IDLE:  busy   = 1'b0;
            ST_CLEAR: clr_en = 1'b1;
            ST_RUN:   ready  = 1'b1;
            ST_DRAIN: done   = !pipe_busy;
            default:  busy   = 1'b0;
        endcase
    end

    assert_done_to_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state == ST_IDLE));

    assert_ready_after_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(state == ST_CLEAR));
endmodule

// File: rtl/feature_mem.sv
module feature_mem
    import relabel_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_en,
    input  logic [FL_W-1:0] clr_addr,
    input  logic            wr_en,
    input  logic [FL_W-1:0] wr_addr,
    input  feat_t           wr_data,
    input  logic [FL_W-1:0] lk_addr,
    output feat_t           lk_data,
    input  logic [FL_W-1:0] rd_addr,
    output feat_t           rd_data
);
    feat_t mem [NF];

    generate
        for (genvar i = 0; i < NF; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (clr_en && clr_addr == FL_W'(i))     mem[i] <= FEAT_EMPTY;
                else if (wr_en && wr_addr == FL_W'(i))  mem[i] <= wr_data;
            end
        end
    endgenerate

    assign lk_data = mem[lk_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= FEAT_EMPTY;
        else        rd_data <= mem[rd_addr];
    end

    assert_area_monotone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data.area >= mem[wr_addr].area));

    assert_clear_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> (mem[$past(clr_addr)].area == '0 && mem[$past(clr_addr)].max_r == '0));
endmodule

// File: rtl/relabel_pipe.sv
module relabel_pipe
    import relabel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc,
    input  logic [FP_W-1:0]    in_label,
    input  logic [COORD_W-1:0] in_row,
    input  logic [COORD_W-1:0] in_col,
    input  logic [CNT_W-1:0]   in_count,
    output logic               tbl_rd,
    output logic [FP_W-1:0]    tbl_addr,
    input  logic [FL_W-1:0]    tbl_data,
    output logic [FL_W-1:0]    lk_addr,
    input  feat_t              lk_data,
    output logic               wr_en,
    output logic [FL_W-1:0]    wr_addr,
    output feat_t              wr_data,
    output logic               out_valid,
    output logic [FL_W-1:0]    out_label,
    output logic               pipe_busy
);
    // stage 1: table data arrives, feature record is read
    logic               s1_v, s1_bg;
    logic [COORD_W-1:0] s1_r, s1_c;
    logic [CNT_W-1:0]   s1_n;
    // stage 2: merge and write back
    logic               s2_v, s2_bg;
    logic [FL_W-1:0]    s2_lab;
    logic [COORD_W-1:0] s2_r, s2_c;
    logic [CNT_W-1:0]   s2_n;
    feat_t              s2_old, s2_new, s1_old;
    logic [FL_W-1:0]    s1_fin;
    logic               fwd;

    assign tbl_rd   = acc && (in_label != '0);
    assign tbl_addr = in_label;

    assign s1_fin  = s1_bg ? '0 : tbl_data;
    assign lk_addr = s1_fin;
    assign s2_new  = feat_merge(s2_old, s2_r, s2_c, s2_n);
    assign fwd     = s2_v && !s2_bg && (s2_lab == s1_fin);
    assign s1_old  = fwd ? s2_new : lk_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_v  <= 1'b0;
            s1_bg <= 1'b1;
            s1_r  <= '0;
            s1_c  <= '0;
            s1_n  <= '0;
        end else begin
            s1_v  <= acc;
            s1_bg <= (in_label == '0);
            s1_r  <= in_row;
            s1_c  <= in_col;
            s1_n  <= in_count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_v   <= 1'b0;
            s2_bg  <= 1'b1;
            s2_lab <= '0;
            s2_r   <= '0;
            s2_c   <= '0;
            s2_n   <= '0;
            s2_old <= FEAT_EMPTY;
        end else begin
            s2_v   <= s1_v;
            s2_bg  <= s1_bg;
            s2_lab <= s1_fin;
            s2_r   <= s1_r;
            s2_c   <= s1_c;
            s2_n   <= s1_n;
            s2_old <= s1_old;
        end
    end

    assign wr_en     = s2_v && !s2_bg;
    assign wr_addr   = s2_lab;
    assign wr_data   = s2_new;
    assign out_valid = s2_v;
    assign out_label = s2_lab;
    assign pipe_busy = s1_v || s2_v;

    assert_bg_no_lookup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(tbl_rd, 2));
endmodule

// File: rtl/relabel_feature_acc.sv
module relabel_feature_acc
    import relabel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               in_valid,
    input  logic [FP_W-1:0]    in_label,
    input  logic [COORD_W-1:0] in_row,
    input  logic [COORD_W-1:0] in_col,
    input  logic [CNT_W-1:0]   in_count,
    input  logic               in_last,
    output logic               ready,
    output logic               tbl_rd,
    output logic [FP_W-1:0]    tbl_addr,
    input  logic [FL_W-1:0]    tbl_data,
    output logic               out_valid,
    output logic [FL_W-1:0]    out_label,
    output logic               busy,
    output logic               done,
    input  logic [FL_W-1:0]    fm_addr,
    output logic [AREA_W-1:0]  fm_area,
    output logic [COORD_W-1:0] fm_top,
    output logic [COORD_W-1:0] fm_left,
    output logic [SIZE_W-1:0]  fm_height,
    output logic [SIZE_W-1:0]  fm_width
);
    state_t          state;
    logic            clr_en, pipe_busy, wr_en;
    logic [FL_W-1:0] clr_addr, wr_addr, lk_addr;
    feat_t           wr_data, lk_data, rd_data;

    relabel_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_last(in_last), .pipe_busy(pipe_busy), .state(state), .ready(ready),
        .clr_en(clr_en), .clr_addr(clr_addr), .busy(busy), .done(done)
    );

    relabel_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .acc(in_valid && ready), .in_label(in_label),
        .in_row(in_row), .in_col(in_col), .in_count(in_count),
        .tbl_rd(tbl_rd), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .lk_addr(lk_addr), .lk_data(lk_data), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_valid(out_valid), .out_label(out_label),
        .pipe_busy(pipe_busy)
    );

    feature_mem u_mem (
        .clk(clk), .rst_n(rst_n), .clr_en(clr_en), .clr_addr(clr_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .lk_addr(lk_addr), .lk_data(lk_data), .rd_addr(fm_addr), .rd_data(rd_data)
    );

    logic has_px;
    assign has_px    = (rd_data.area != '0);
    assign fm_area   = rd_data.area;
    assign fm_top    = rd_data.min_r;
    assign fm_left   = rd_data.min_c;
    assign fm_height = has_px ? ({1'b0, rd_data.max_r} - {1'b0, rd_data.min_r} + 1'b1) : '0;
    assign fm_width  = has_px ? ({1'b0, rd_data.max_c} - {1'b0, rd_data.min_c} + 1'b1) : '0;

    assert_no_accept_outside_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd |-> (state == ST_RUN));
endmodule

// File: tb/tb_relabel_feature_acc.sv
module tb_relabel_feature_acc;
    import relabel_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic [FP_W-1:0] in_label = '0;
    logic [COORD_W-1:0] in_row = '0, in_col = '0;
    logic [CNT_W-1:0] in_count = '0;
    logic ready, tbl_rd, out_valid, busy, done;
    logic [FP_W-1:0] tbl_addr;
    logic [FL_W-1:0] tbl_data, out_label, fm_addr = '0;
    logic [AREA_W-1:0] fm_area;
    logic [COORD_W-1:0] fm_top, fm_left;
    logic [SIZE_W-1:0] fm_height, fm_width;

    int checks = 0, fails = 0;
    logic [FL_W-1:0] tbl [1 << FP_W];
    int got[$];

    always #5 clk = ~clk;

    always @(posedge clk) if (tbl_rd) tbl_data <= tbl[tbl_addr];
    always @(negedge clk) if (out_valid) got.push_back(int'(out_label));

    relabel_feature_acc dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic begin_pass();
        int n;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        n = 0;
        while (!ready && n < 1000) begin n++; @(negedge clk); end
        chk(n == NF, "R2 clear cycles", n, NF);
    endtask

    task automatic send(input int lab, input int r, input int c, input int n, input bit last);
        @(negedge clk);
        in_valid = 1'b1; in_label = FP_W'(lab); in_row = COORD_W'(r);
        in_col = COORD_W'(c); in_count = CNT_W'(n); in_last = last;
        #1;
        if (lab == 0) chk(tbl_rd == 1'b0, "R4 no table read", int'(tbl_rd), 0);
        else chk(tbl_rd && tbl_addr == FP_W'(lab), "R3 table read", int'(tbl_addr), lab);
    endtask

    task automatic finish_pass();
        int n;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(ready == 1'b0, "R8 ready drops after last", int'(ready), 0);
        n = 0;
        while (!done && n < 100) begin n++; @(negedge clk); end
        chk(n == 2, "R8 done timing", n, 2);
        @(negedge clk);
        chk(busy == 1'b0, "R8 idle after done", int'(busy), 0);
    endtask

    task automatic read_feat(input int a, input int ea, input int et, input int el,
                             input int eh, input int ew, input string tag);
        @(negedge clk) fm_addr = FL_W'(a);
        @(negedge clk);
        chk(fm_area == AREA_W'(ea), {tag, " area"}, int'(fm_area), ea);
        chk(fm_top == COORD_W'(et) && fm_left == COORD_W'(el), {tag, " top-left"},
            int'(fm_top) * 100 + int'(fm_left), et * 100 + el);
        chk(fm_height == SIZE_W'(eh) && fm_width == SIZE_W'(ew), {tag, " size"},
            int'(fm_height) * 100 + int'(fm_width), eh * 100 + ew);
    endtask

    task automatic t_reset();
        chk(!busy && !ready && !out_valid && !done, "R1 reset outputs",
            {busy, ready, out_valid, done}, 0);
    endtask

    task automatic t_idle_ignore();
        got.delete();
        @(negedge clk);
        in_valid = 1'b1; in_label = 6'd1; in_count = 3'd4;
        #1 chk(tbl_rd == 1'b0, "R8 idle input no lookup", int'(tbl_rd), 0);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk(got.size() == 0, "R8 idle input no output", got.size(), 0);
    endtask

    task automatic t_frame_main();
        int exp[8] = '{1, 1, 0, 1, 2, 1, 1, 3};
        got.delete();
        begin_pass();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(ready == 1'b1, "R2 start ignored while busy", int'(ready), 1);
        send(1, 2, 3, 4, 0);
        send(1, 2, 4, 2, 0);   // same label back to back: R7
        send(0, 2, 5, 0, 0);   // background: R4
        send(3, 3, 2, 1, 0);   // maps to final 1: R10
        send(2, 4, 6, 3, 0);
        send(3, 5, 3, 4, 0);
        send(1, 5, 4, 3, 0);   // different first-pass, same final, back to back: R7
        send(5, 7, 9, 2, 1);
        finish_pass();
        chk(got.size() == 8, "R3 stream length", got.size(), 8);
        for (int i = 0; i < 8 && i < got.size(); i++)
            chk(got[i] == exp[i], "R3 final label stream", got[i], exp[i]);
        read_feat(1, 14, 2, 2, 4, 3, "R5 R6 R7 R10 R9 final1");
        read_feat(2, 3, 4, 6, 1, 1, "R6 final2");
        read_feat(3, 2, 7, 9, 1, 1, "R5 final3");
        read_feat(4, 0, 63, 63, 0, 0, "R2 untouched entry");
        read_feat(0, 0, 63, 63, 0, 0, "R4 background entry");
    endtask

    task automatic t_latency_and_reclear();
        got.delete();
        begin_pass();
        send(2, 1, 1, 1, 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        chk(out_valid == 1'b0, "R3 no output after one edge", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid && out_label == 4'd2, "R3 output after two edges",
            int'(out_label), 2);
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R8 idle after short frame", int'(busy), 0);
        read_feat(1, 0, 63, 63, 0, 0, "R2 cleared between passes");
        read_feat(2, 1, 1, 1, 1, 1, "R5 second pass");
    endtask

    initial begin
        for (int i = 0; i < (1 << FP_W); i++) tbl[i] = '0;
        tbl[1] = 4'd1; tbl[2] = 4'd2; tbl[3] = 4'd1; tbl[5] = 4'd3;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle_ignore();
        t_frame_main();
        t_latency_and_reclear();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule